// File: doc/BRIEF.md
# DMA Channel-Enable and Interrupt Register Bank

This block is the control-and-status register bank of a multi-channel DMA controller. It holds one enable bit per channel, a global on/off bit and, for each of five interrupt classes, a set of raw, masked-status, mask and clear registers with one bit per channel. Event pulses from the transfer engine set raw bits. The masked status of every class folds into a five-bit summary, and one interrupt line is driven from that summary.

Software reaches the bank through a plain single-cycle register port. A write lands on the clock edge where `reg_we` is high. A read is combinational from `reg_addr`. Channel-enable and mask registers use a paired write-enable scheme: bit `n` of the stored value changes only when bit `n+8` of the written word is one. Because of this, one channel's enable or mask bit can be changed without first reading the register back. The engine reports a finished channel on `ch_done_i`, which drops that channel's enable bit. A channel whose enable bit reads as one is busy.

The interrupt classes have fixed indices. Index 0 is transfer complete, 1 is block complete, 2 is source transaction, 3 is destination transaction and 4 is error. Event input `irq_evt_i[t*NCH + n]` belongs to class `t`, channel `n`.

Top module: `dma_irq_regbank`

## Requirements
- R1: After reset, every register in the bank reads zero, `ch_en_o` is zero, `glb_en_o` is zero and `irq_o` is low.
- R2: A write to word address 0 loads bit 0 of the data into the global enable. Reading address 0 returns that bit in bit 0. `glb_en_o` shows the same value.
- R3: A write to the channel-enable register (word address 1) leaves enable bit `n` unchanged when data bit `n+8` is zero.
- R4: In a write to address 1 where data bit `n+8` is one, enable bit `n` takes the value of data bit `n`. Reading address 1 returns the enable bits in bits `NCH-1:0`, and `ch_en_o` mirrors them.
- R5: A one on `ch_done_i[n]` clears enable bit `n` at the next edge. This takes priority over a write that sets the same bit in the same cycle.
- R6: The mask register of class `t` (word address 12+t) follows the same paired write-enable rule as R3 and R4. Reading it returns the mask bits.
- R7: A one on an event input sets the matching raw bit (read at word address 2+t). The bit stays set until cleared. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R8: Writing a one to bit `n` of the clear register of class `t` (word address 17+t) clears raw bit `n` of that class. Bits written as zero and other classes are untouched. Clear registers read as zero.
- R9: The status register of class `t` (word address 7+t) reads raw AND mask for that class.
- R10: The summary register (word address 22) has bit `t` set exactly when any status bit of class `t` is set.
- R11: `irq_o` is the OR of the summary bits while the global enable is one. It is low whenever the global enable is zero, even with status pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data, zero for unmapped addresses |
| irq_evt_i | input | 5*NCH | Event pulses, class t channel n at bit t*NCH+n |
| ch_done_i | input | NCH | Channel-finished pulses from the engine |
| ch_en_o | output | NCH | Channel enable (busy) bits |
| glb_en_o | output | 1 | Global controller enable |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The hardest case to reach from the ports is a collision in a single clock cycle. One example is a clear write and an event pulse on the same raw bit. Another is a software write that sets an enable bit while the engine reports that same channel finished. The stimulus drives the register strobe and the event or done input together on one falling edge, so both arrive at the same rising edge. The bench then reads the bit back. Partial paired writes are also exercised: only some write-enable bits are set, and the unselected bits are checked to hold their earlier values.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  // number of interrupt classes and their indices
  localparam int NTYPE   = 5;
  localparam int T_XFER  = 0;
  localparam int T_BLOCK = 1;
  localparam int T_SRC   = 2;
  localparam int T_DST   = 3;
  localparam int T_ERR   = 4;
  // offset of the paired write-enable field inside a write word
  localparam int WE_OFS  = 8;
  // word address map
  localparam int A_GLB   = 0;
  localparam int A_CHEN  = 1;
  localparam int A_RAW0  = 2;
  localparam int A_STAT0 = A_RAW0 + NTYPE;
  localparam int A_MASK0 = A_STAT0 + NTYPE;
  localparam int A_CLR0  = A_MASK0 + NTYPE;
  localparam int A_SUM   = A_CLR0 + NTYPE;
endpackage

// File: rtl/we_bitreg.sv
// Bit register with paired write-enable update and hardware clear.
module we_bitreg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] val,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] hw_clr,
  output logic [N-1:0] q
);
  logic [N-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr) nxt = (q & ~sel) | (val & sel);
    nxt = nxt & ~hw_clr;  // engine clear has the last word
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/irq_class.sv
// One interrupt class: raw latch, mask, masked status and any-pending flag.
module irq_class #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_val,
  input  logic [N-1:0] mask_sel,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic [N-1:0] stat,
  output logic         any
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~clr_eff) | evt;  // set beats clear
  end

  we_bitreg #(.N(N)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (mask_wr),
    .val    (mask_val),
    .sel    (mask_sel),
    .hw_clr ({N{1'b0}}),
    .q      (mask)
  );

  assign stat = raw & mask;
  assign any  = |stat;
endmodule

// File: rtl/dma_irq_regbank.sv
// Channel-enable and interrupt register bank. NCH must not exceed WE_OFS.
module dma_irq_regbank
  import dmairq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [NTYPE*NCH-1:0] irq_evt_i,
  input  logic [NCH-1:0]       ch_done_i,
  output logic [NCH-1:0]       ch_en_o,
  output logic                 glb_en_o,
  output logic                 irq_o
);
  localparam int TOT = NTYPE * NCH;

  logic [NCH-1:0]   wr_val, wr_sel;
  logic             glb_q;
  logic [TOT-1:0]   raw_all, mask_all, stat_all;
  logic [NTYPE-1:0] summ;
  logic             unused_wdata;

  assign wr_val       = reg_wdata[NCH-1:0];
  assign wr_sel       = reg_wdata[WE_OFS +: NCH];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glb_q <= 1'b0;
    else if (reg_we && reg_addr == ADDR_W'(A_GLB)) glb_q <= reg_wdata[0];
  end

  we_bitreg #(.N(NCH)) u_chen (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_we && reg_addr == ADDR_W'(A_CHEN)),
    .val    (wr_val),
    .sel    (wr_sel),
    .hw_clr (ch_done_i),
    .q      (ch_en_o)
  );

  for (genvar t = 0; t < NTYPE; t++) begin : g_cls
    irq_class #(.N(NCH)) u_cls (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (irq_evt_i[t*NCH +: NCH]),
      .clr_wr   (reg_we && reg_addr == ADDR_W'(A_CLR0 + t)),
      .clr_bits (wr_val),
      .mask_wr  (reg_we && reg_addr == ADDR_W'(A_MASK0 + t)),
      .mask_val (wr_val),
      .mask_sel (wr_sel),
      .raw      (raw_all[t*NCH +: NCH]),
      .mask     (mask_all[t*NCH +: NCH]),
      .stat     (stat_all[t*NCH +: NCH]),
      .any      (summ[t])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_GLB))  reg_rdata[0] = glb_q;
    if (reg_addr == ADDR_W'(A_CHEN)) reg_rdata[NCH-1:0] = ch_en_o;
    if (reg_addr == ADDR_W'(A_SUM))  reg_rdata[NTYPE-1:0] = summ;
    for (int t = 0; t < NTYPE; t++) begin
      if (reg_addr == ADDR_W'(A_RAW0 + t))  reg_rdata[NCH-1:0] = raw_all[t*NCH +: NCH];
      if (reg_addr == ADDR_W'(A_STAT0 + t)) reg_rdata[NCH-1:0] = stat_all[t*NCH +: NCH];
      if (reg_addr == ADDR_W'(A_MASK0 + t)) reg_rdata[NCH-1:0] = mask_all[t*NCH +: NCH];
    end
  end

  assign glb_en_o = glb_q;
  assign irq_o    = glb_q & (|summ);
endmodule

// File: rtl/dma_irq_regbank_chk.sv
module dma_irq_regbank_chk
  import dmairq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [DATA_W-1:0]    reg_wdata,
  input logic [NTYPE*NCH-1:0] irq_evt_i,
  input logic [NCH-1:0]       ch_done_i,
  input logic [NCH-1:0]       ch_en_o,
  input logic                 glb_en_o,
  input logic                 irq_o,
  input logic [NTYPE*NCH-1:0] raw_all,
  input logic [NTYPE*NCH-1:0] mask_all
);
  logic chen_wr;
  assign chen_wr = reg_we && reg_addr == ADDR_W'(A_CHEN);

  // R3: unselected enable bits hold (engine clear excepted)
  a_r3_chen_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
    chen_wr |=> ((ch_en_o ^ $past(ch_en_o)) & ~$past(reg_wdata[WE_OFS +: NCH])
                 & ~$past(ch_done_i)) == '0);

  // R3: no enable change at all without a write or an engine clear
  a_r3_chen_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !chen_wr |=> ((ch_en_o ^ $past(ch_en_o)) & ~$past(ch_done_i)) == '0);

  // R5: finished channel is disabled next cycle
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_done_i) |=> (ch_en_o & $past(ch_done_i)) == '0);

  // R7: every event pulse leaves its raw bit set
  a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_evt_i) |=> (raw_all & $past(irq_evt_i)) == $past(irq_evt_i));

  // R11: no interrupt while the controller is off
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_o |-> !irq_o);

  for (genvar t = 0; t < NTYPE; t++) begin : g_t
    // R8: raw bits only fall through a clear write of their own class
    a_r8_raw_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == ADDR_W'(A_CLR0 + t)) |=>
        ($past(raw_all[t*NCH +: NCH]) & ~raw_all[t*NCH +: NCH]) == '0);
    // R6: mask bits change only where the write-enable half is set
    a_r6_mask_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(A_MASK0 + t)) |=>
        ((mask_all[t*NCH +: NCH] ^ $past(mask_all[t*NCH +: NCH]))
         & ~$past(reg_wdata[WE_OFS +: NCH])) == '0);
  end
endmodule

bind dma_irq_regbank dma_irq_regbank_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_evt_i (irq_evt_i),
  .ch_done_i (ch_done_i),
  .ch_en_o   (ch_en_o),
  .glb_en_o  (glb_en_o),
  .irq_o     (irq_o),
  .raw_all   (raw_all),
  .mask_all  (mask_all)
);

// File: tb/tb_dma_irq_regbank.sv
`timescale 1ns/1ps
module tb_dma_irq_regbank;
  localparam int NCH = 8;
  localparam int AW  = 5;
  localparam int DW  = 32;
  localparam int NT  = 5;
  // address map as stated in the requirements
  localparam int A_GLB = 0, A_CHEN = 1, A_RAW0 = 2, A_STAT0 = 7,
                 A_MASK0 = 12, A_CLR0 = 17, A_SUM = 22;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [DW-1:0]  reg_wdata = '0;
  logic [DW-1:0]  reg_rdata;
  logic [NT*NCH-1:0] irq_evt_i = '0;
  logic [NCH-1:0] ch_done_i = '0;
  logic [NCH-1:0] ch_en_o;
  logic           glb_en_o;
  logic           irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  dma_irq_regbank #(.NCH(NCH), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_evt_i(irq_evt_i),
    .ch_done_i(ch_done_i), .ch_en_o(ch_en_o), .glb_en_o(glb_en_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic evt(input int t, input logic [NCH-1:0] v);
    @(negedge clk);
    irq_evt_i[t*NCH +: NCH] = v;
    @(negedge clk);
    irq_evt_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 ch_en_o", 32'(ch_en_o), 0);
    chk("R1 irq_o", 32'(irq_o), 0);
    for (int a = 0; a <= A_SUM; a++) begin
      rd(a, d);
      chk($sformatf("R1 addr %0d", a), d, 0);
    end
  endtask

  task automatic t_global();
    logic [31:0] d;
    wr(A_GLB, 1);
    rd(A_GLB, d); chk("R2 read on", d, 1);
    chk("R2 glb_en_o on", 32'(glb_en_o), 1);
    wr(A_GLB, 0);
    rd(A_GLB, d); chk("R2 read off", d, 0);
  endtask

  task automatic t_chen();
    logic [31:0] d;
    wr(A_CHEN, 32'h0101);
    rd(A_CHEN, d); chk("R4 set ch0", d, 32'h01);
    wr(A_CHEN, 32'h00FE);
    rd(A_CHEN, d); chk("R3 no write-enable", d, 32'h01);
    wr(A_CHEN, 32'h0F0A);
    rd(A_CHEN, d); chk("R4 mixed set/clear", d, 32'h0A);
    wr(A_CHEN, 32'h0200);
    rd(A_CHEN, d); chk("R4 clear ch1", d, 32'h08);
    chk("R4 ch_en_o mirror", 32'(ch_en_o), 32'h08);
  endtask

  task automatic t_done();
    logic [31:0] d;
    @(negedge clk); ch_done_i = 8'h08;
    @(negedge clk); ch_done_i = '0;
    rd(A_CHEN, d); chk("R5 done clears ch3", d, 0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(A_CHEN); reg_wdata = 32'h3030; ch_done_i = 8'h20;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; ch_done_i = '0;
    rd(A_CHEN, d); chk("R5 done beats write", d, 32'h10);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_MASK0 + 1, 32'h0303);
    rd(A_MASK0 + 1, d); chk("R6 mask set", d, 32'h03);
    wr(A_MASK0 + 1, 32'h00FF);
    rd(A_MASK0 + 1, d); chk("R6 mask no write-enable", d, 32'h03);
    rd(A_MASK0 + 2, d); chk("R6 other class mask", d, 0);
  endtask

  task automatic t_raw_status();
    logic [31:0] d;
    evt(1, 8'h05);
    rd(A_RAW0 + 1, d);  chk("R7 raw set", d, 32'h05);
    rd(A_RAW0 + 0, d);  chk("R7 other class raw", d, 0);
    rd(A_STAT0 + 1, d); chk("R9 status", d, 32'h01);
    rd(A_SUM, d);       chk("R10 summary", d, 32'h02);
    chk("R11 irq off while disabled", 32'(irq_o), 0);
    wr(A_GLB, 1);
    #1 chk("R11 irq on", 32'(irq_o), 1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A_CLR0 + 1, 32'h04);
    rd(A_RAW0 + 1, d); chk("R8 clear ch2 only", d, 32'h01);
    rd(A_CLR0 + 1, d); chk("R8 clear reads zero", d, 0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(A_CLR0 + 1); reg_wdata = 32'h01;
    irq_evt_i[1*NCH +: NCH] = 8'h01;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; irq_evt_i = '0;
    rd(A_RAW0 + 1, d); chk("R7 set beats clear", d, 32'h01);
    wr(A_CLR0 + 1, 32'h01);
    rd(A_RAW0 + 1, d); chk("R8 raw cleared", d, 0);
    rd(A_SUM, d);      chk("R10 summary empty", d, 0);
    #1 chk("R11 irq drops", 32'(irq_o), 0);
  endtask

  task automatic t_error_class();
    logic [31:0] d;
    wr(A_MASK0 + 4, 32'h8080);
    evt(4, 8'h81);
    rd(A_STAT0 + 4, d); chk("R9 error status", d, 32'h80);
    rd(A_SUM, d);       chk("R10 error summary", d, 32'h10);
    #1 chk("R11 irq error", 32'(irq_o), 1);
    wr(A_GLB, 0);
    #1 chk("R11 gated by global off", 32'(irq_o), 0);
  endtask

  initial begin
    #(8 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_global();
    t_chen();
    t_done();
    t_mask();
    t_raw_status();
    t_clear();
    t_error_class();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule